// File: doc/BRIEF.md
# Charger Power Switch Controller

This block is the digital supervisor of the switch that connects a charger to a battery. It sees the analog side only through comparator flags that have already been digitized. These flags report whether the charger is above its power-on-reset level and where the output sits relative to three levels: the startup cutoff, the startup re-enable level and the selected overvoltage limit. It also takes a limit-select level and the PWM waveform from charging software. It drives three outputs: the startup-current enable, the main switch enable and a protection flag. It also drives the limit selection onward to the limit comparator.

When the charger is present and software is not running PWM, a hysteresis loop trickle-charges the battery. The loop cuts the startup current off at the cutoff level and turns it back on only below the lower re-enable level. Once PWM runs, the block measures its period in system-clock cycles. Slow PWM drives the switch directly. Fast PWM holds the switch closed.

An overvoltage condition opens the switch in the same cycle it appears and latches a protection state. That state is released in either of two cases:

- the output has returned below the limit and PWM has been seen low;
- the charger has dropped below its power-on-reset level.

Top module: `chg_switch_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `start_en_o`, `sw_en_o`, `prot_o` and `lim_hi_o` are all 0.
- R2: With the charger present and PWM idle, startup current turns on when the output is below the re-enable level (`vout_gt_reen_i`=0). It turns off when the output is above the cutoff (`vout_gt_start_i`=1). In between, it keeps its previous state.
- R3: Startup current is off whenever the charger is below its power-on-reset level or PWM is active (not idle).
- R4: `lim_hi_o` follows `lim_hi_sel_i` (1 = upper limit, 0 = lower limit) three clock edges after a change. It is 0 after reset.
- R5: While `vout_gt_lim_i` is 1, `sw_en_o` is 0 in the same cycle, with no synchronizer delay.
- R6: An overvoltage sets `prot_o`. Protection is cleared once both of these have been seen, in either order: `vout_lt_lim_i`=1 and PWM low. Until then, `prot_o` stays 1 and the switch stays open.
- R7: With PWM held high and the charger present, protection persists. The charger falling below its power-on-reset level clears protection.
- R8: In slow mode the switch is closed while PWM is high and open while PWM is low (charger present, no protection).
- R9: Two consecutive PWM rising-edge intervals shorter than `FAST_THR` cycles select fast mode. In fast mode the switch stays closed whatever the PWM level.
- R10: PWM low for `SLOW_TO` cycles, or never high since reset, makes PWM idle. Idle leaves fast mode, opens the switch and hands control to the startup loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_por_ok_i | input | 1 | Charger above power-on-reset level |
| vout_gt_start_i | input | 1 | Output above startup cutoff |
| vout_gt_reen_i | input | 1 | Output above startup re-enable level |
| vout_gt_lim_i | input | 1 | Output above selected overvoltage limit |
| vout_lt_lim_i | input | 1 | Output below selected overvoltage limit |
| lim_hi_sel_i | input | 1 | Limit select: 1 upper, 0 lower |
| pwm_i | input | 1 | Software charging PWM |
| start_en_o | output | 1 | Startup current enable |
| sw_en_o | output | 1 | Main power switch enable |
| prot_o | output | 1 | Overvoltage protection active |
| lim_hi_o | output | 1 | Registered limit select to the comparator |

## Verification
The overvoltage cut and the fast-mode hold can both act in the same cycle: fast mode wants the switch closed while the overvoltage flag demands it open. The bench first builds fast mode with a train of short PWM periods. It then raises the overvoltage flag half a clock before an edge. One nanosecond later it requires `sw_en_o` to be 0, before any register could have reacted. It next confirms that protection holds while PWM stays high. Finally it checks that, once PWM drops, fast mode closes the switch again even though PWM is low.

// File: rtl/chgsw_pkg.sv
`timescale 1ns/1ps
package chgsw_pkg;
  typedef enum logic [1:0] {
    RATE_IDLE = 2'd0,
    RATE_SLOW = 2'd1,
    RATE_FAST = 2'd2
  } rate_e;

  localparam int FAST_RUN_NEED = 2;
endpackage

// File: rtl/chgsw_sync.sv
`timescale 1ns/1ps
module chgsw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chgsw_rate_det.sv
`timescale 1ns/1ps
module chgsw_rate_det
  import chgsw_pkg::*;
#(
  parameter int SLOW_TO  = 200,
  parameter int FAST_THR = 100
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pwm_s,
  output rate_e rate
);
  localparam int CW = $clog2(SLOW_TO + 1);
  localparam logic [CW-1:0] CMAX = CW'(SLOW_TO);
  localparam logic [CW-1:0] CTHR = CW'(FAST_THR);

  logic          pwm_d;
  logic [CW-1:0] per_cnt;
  logic [CW-1:0] low_cnt;
  logic [1:0]    fast_run;
  logic          rise;
  logic          idle;

  assign rise = pwm_s & ~pwm_d;
  assign idle = (low_cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_d    <= 1'b0;
      per_cnt  <= CMAX;
      low_cnt  <= CMAX;
      fast_run <= '0;
    end else begin
      pwm_d <= pwm_s;
      if (pwm_s)             low_cnt <= '0;
      else if (!idle)        low_cnt <= low_cnt + 1'b1;
      if (idle)              fast_run <= '0;
      if (rise) begin
        per_cnt <= CW'(1);
        if (per_cnt < CTHR)
          fast_run <= (fast_run == 2'(FAST_RUN_NEED)) ? fast_run : fast_run + 1'b1;
        else
          fast_run <= '0;
      end else if (per_cnt != CMAX) begin
        per_cnt <= per_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (idle)                                rate = RATE_IDLE;
    else if (fast_run == 2'(FAST_RUN_NEED))  rate = RATE_FAST;
    else                                     rate = RATE_SLOW;
  end
endmodule

// File: rtl/chgsw_ovp.sv
`timescale 1ns/1ps
module chgsw_ovp (
  input  logic clk,
  input  logic rst,
  input  logic chg_ok_s,
  input  logic gt_lim_s,
  input  logic lt_lim_s,
  input  logic pwm_s,
  output logic prot_q
);
  logic below_seen;
  logic low_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q     <= 1'b0;
      below_seen <= 1'b0;
      low_seen   <= 1'b0;
    end else if (gt_lim_s) begin
      prot_q     <= 1'b1;
      below_seen <= 1'b0;
      low_seen   <= 1'b0;
    end else if (prot_q) begin
      if (!chg_ok_s) begin
        prot_q     <= 1'b0;
        below_seen <= 1'b0;
        low_seen   <= 1'b0;
      end else if ((below_seen | lt_lim_s) && (low_seen | ~pwm_s)) begin
        prot_q     <= 1'b0;
        below_seen <= 1'b0;
        low_seen   <= 1'b0;
      end else begin
        below_seen <= below_seen | lt_lim_s;
        low_seen   <= low_seen | ~pwm_s;
      end
    end
  end
endmodule

// File: rtl/chgsw_startup.sv
`timescale 1ns/1ps
module chgsw_startup (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic gt_start_s,
  input  logic gt_reen_s,
  output logic start_q
);
  logic start_d;

  always_comb begin
    if (!allow)          start_d = 1'b0;
    else if (start_q)    start_d = ~gt_start_s;
    else                 start_d = ~gt_reen_s;
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_d;
  end
endmodule

// File: rtl/chg_switch_ctrl.sv
`timescale 1ns/1ps
module chg_switch_ctrl
  import chgsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_TO     = 200,
  parameter int FAST_THR    = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_por_ok_i,
  input  logic vout_gt_start_i,
  input  logic vout_gt_reen_i,
  input  logic vout_gt_lim_i,
  input  logic vout_lt_lim_i,
  input  logic lim_hi_sel_i,
  input  logic pwm_i,
  output logic start_en_o,
  output logic sw_en_o,
  output logic prot_o,
  output logic lim_hi_o
);
  localparam int NIN = 7;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] syn_in;
  logic chg_s, gt_start_s, gt_reen_s, gt_lim_s, lt_lim_s, lim_s, pwm_s;
  rate_e rate;
  logic  idle;
  logic  prot_q;
  logic  start_q;
  logic  sw_q;
  logic  sw_d;
  logic  lim_q;

  assign raw_in = {chg_por_ok_i, vout_gt_start_i, vout_gt_reen_i,
                   vout_gt_lim_i, vout_lt_lim_i, lim_hi_sel_i, pwm_i};

  chgsw_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign {chg_s, gt_start_s, gt_reen_s, gt_lim_s, lt_lim_s, lim_s, pwm_s} = syn_in;

  chgsw_rate_det #(.SLOW_TO(SLOW_TO), .FAST_THR(FAST_THR)) u_rate (
    .clk(clk), .rst(rst), .pwm_s(pwm_s), .rate(rate)
  );

  assign idle = (rate == RATE_IDLE);

  chgsw_ovp u_ovp (
    .clk(clk), .rst(rst), .chg_ok_s(chg_s), .gt_lim_s(gt_lim_s),
    .lt_lim_s(lt_lim_s), .pwm_s(pwm_s), .prot_q(prot_q)
  );

  chgsw_startup u_start (
    .clk(clk), .rst(rst), .allow(chg_s & idle),
    .gt_start_s(gt_start_s), .gt_reen_s(gt_reen_s), .start_q(start_q)
  );

  always_comb begin
    sw_d = 1'b0;
    if (chg_s && !prot_q && !gt_lim_s) begin
      case (rate)
        RATE_FAST: sw_d = 1'b1;
        RATE_SLOW: sw_d = pwm_s;
        default:   sw_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q  <= 1'b0;
      lim_q <= 1'b0;
    end else begin
      sw_q  <= sw_d;
      lim_q <= lim_s;
    end
  end

  assign sw_en_o    = sw_q & ~vout_gt_lim_i;
  assign start_en_o = start_q;
  assign prot_o     = prot_q;
  assign lim_hi_o   = lim_q;
endmodule

// File: rtl/chgsw_checker.sv
`timescale 1ns/1ps
module chgsw_checker (
  input logic clk,
  input logic rst,
  input logic vout_gt_lim_i,
  input logic sw_en_o,
  input logic chg_s,
  input logic pwm_s,
  input logic idle,
  input logic prot_q,
  input logic sw_q,
  input logic start_q
);
  // R5: raw overvoltage forces the switch open in the same cycle
  a_r5_ov_opens_now: assert property (@(posedge clk) disable iff (rst)
    vout_gt_lim_i |-> !sw_en_o);

  // R7: protection persists while PWM high and charger present
  a_r7_prot_holds: assert property (@(posedge clk) disable iff (rst)
    (prot_q && pwm_s && chg_s) |=> prot_q);

  // R6: protection keeps the switch register open
  a_r6_prot_blocks_sw: assert property (@(posedge clk) disable iff (rst)
    prot_q |=> !sw_q);

  // R3: startup current off once PWM is active
  a_r3_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    !idle |=> !start_q);

  // R3: startup current off without a charger
  a_r3_no_start_no_chg: assert property (@(posedge clk) disable iff (rst)
    !chg_s |=> !start_q);

  // R10: idle PWM keeps the switch open
  a_r10_idle_open: assert property (@(posedge clk) disable iff (rst)
    idle |=> !sw_q);
endmodule

bind chg_switch_ctrl chgsw_checker u_chk (
  .clk(clk), .rst(rst), .vout_gt_lim_i(vout_gt_lim_i), .sw_en_o(sw_en_o),
  .chg_s(chg_s), .pwm_s(pwm_s), .idle(idle), .prot_q(prot_q),
  .sw_q(sw_q), .start_q(start_q)
);

// File: tb/tb_chg_switch_ctrl.sv
`timescale 1ns/1ps
module tb_chg_switch_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg = 0, gts = 0, gtr = 0, gtl = 0, ltl = 1, limh = 0, pwm = 0;
  logic start_en, sw_en, prot, lim_hi;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always #2.5 clk = ~clk;

  chg_switch_ctrl dut (
    .clk(clk), .rst(rst), .chg_por_ok_i(chg), .vout_gt_start_i(gts),
    .vout_gt_reen_i(gtr), .vout_gt_lim_i(gtl), .vout_lt_lim_i(ltl),
    .lim_hi_sel_i(limh), .pwm_i(pwm), .start_en_o(start_en),
    .sw_en_o(sw_en), .prot_o(prot), .lim_hi_o(lim_hi)
  );

  // inputs {chg,gt_start,gt_reen,gt_lim,lt_lim,lim_sel,pwm} | expect {start,sw,prot,lim}
  localparam logic [10:0] VEC [0:9] = '{
    11'b0000100_0000,
    11'b1000100_1000,
    11'b1010100_1000,
    11'b1110100_0000,
    11'b1010100_0000,
    11'b1000100_1000,
    11'b0000100_0000,
    11'b1110110_0001,
    11'b1111010_0011,
    11'b1110110_0001
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    // R1: outputs low during reset
    chk("R1 start", start_en, 1'b0);
    chk("R1 sw", sw_en, 1'b0);
    chk("R1 prot", prot, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 lim", lim_hi, 1'b0);

    for (int i = 0; i < 10; i++) begin
      {chg, gts, gtr, gtl, ltl, limh, pwm} = VEC[i][10:4];
      step(6);
      chk((i == 0 || i == 6) ? "R3 start" : "R2 start", start_en, VEC[i][3]);
      chk("R10 sw", sw_en, VEC[i][2]);
      chk("R6 prot", prot, VEC[i][1]);
      chk("R4 lim", lim_hi, VEC[i][0]);
    end

    // slow PWM, startup blocked
    {chg, gts, gtr, gtl, ltl, limh} = 6'b111010;
    pwm = 1; step(5);
    chk("R8 sw high", sw_en, 1'b1);
    chk("R3 start busy", start_en, 1'b0);
    pwm = 0; step(5);
    chk("R8 sw low", sw_en, 1'b0);

    // fast PWM train
    for (int p = 0; p < 4; p++) begin
      pwm = 1; step(20);
      pwm = 0; step(20);
    end
    pwm = 0; step(2);
    chk("R9 fast hold low", sw_en, 1'b1);
    pwm = 1; step(5);

    // overvoltage in fast mode, same cycle
    gtl = 1; ltl = 0; #1;
    chk("R5 same cycle", sw_en, 1'b0);
    step(5);
    chk("R6 prot set", prot, 1'b1);
    gtl = 0; ltl = 1; step(10);
    chk("R7 pwm high holds", prot, 1'b1);
    chk("R6 sw open", sw_en, 1'b0);
    pwm = 0; step(5);
    chk("R6 released", prot, 1'b0);
    step(3);
    chk("R9 fast after release", sw_en, 1'b1);

    // order: PWM low first, voltage later
    pwm = 1; step(5);
    gtl = 1; ltl = 0; step(5);
    pwm = 0; step(8);
    chk("R6 still above", prot, 1'b1);
    gtl = 0; ltl = 1; step(5);
    chk("R6 both seen", prot, 1'b0);

    // charger drop releases
    pwm = 1; step(5);
    gtl = 1; ltl = 0; step(5);
    chk("R6 prot again", prot, 1'b1);
    gtl = 0; ltl = 1; chg = 0; step(5);
    chk("R7 chg release", prot, 1'b0);
    chk("R7 sw no chg", sw_en, 1'b0);
    chg = 1; step(5);
    chk("R7 sw after return", sw_en, 1'b1);

    // idle timeout
    pwm = 0; step(250);
    chk("R10 idle sw", sw_en, 1'b0);
    chk("R10 idle start off", start_en, 1'b0);
    gts = 0; gtr = 0; step(5);
    chk("R10 startup loop", start_en, 1'b1);
    pwm = 1; step(5);
    chk("R3 start stops", start_en, 1'b0);
    chk("R8 slow after idle", sw_en, 1'b1);
    pwm = 0; step(10);
    chk("R10 fast left", sw_en, 1'b0);

    // reset mid-run
    limh = 1; step(5);
    chk("R4 lim hi", lim_hi, 1'b1);
    rst = 1; step(2);
    chk("R1 lim reset", lim_hi, 1'b0);
    chk("R1 start reset", start_en, 1'b0);
    rst = 0;
    finish_run();
  end
endmodule